// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a reference clock into a one-cycle oversample strobe at sixteen times the serial bit rate. The divide ratio is the reference frequency over sixteen times the baud rate. It is split into a 16-bit whole part and a 6-bit fraction counted in 1/64 steps. The fraction value is the rounded product of the fractional remainder and 64. For example, a ratio of 1.085 is programmed as whole part 1 and fraction 5, which gives an effective ratio of 1 + 5/64.

A 6-bit accumulator gains the fraction once per strobe period. Each period in which the accumulator wraps is one reference clock longer, so the mean period equals the programmed ratio. Software writes the two divisor parts into holding registers. The transmitter and receiver report the end of each character, and only then does a pending divisor replace the running one. That keeps the bit timing constant for a character already in flight.

Two ratios are not usable, and the block flags each on its own output while it holds the strobe low. A whole part of zero is one. A whole part of 0xFFFF with a non-zero fraction is the other, and it is reported as an abort.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the running and the held divisor are both zero, so `invalid_o` is 1, `abort_o` is 0 and `tick_o` is 0.
- R2: `tick_o` is a single-clock pulse. It is high on two consecutive cycles only when the running whole part is 1.
- R3: With fraction 0, consecutive strobes are exactly the whole part apart in clocks. A whole part of 1 gives a strobe on every clock.
- R4: Each strobe period adds the fraction to a 6-bit accumulator that wraps at 64. A period whose addition wraps lasts whole+1 clocks, so any 64 consecutive periods last exactly 64·whole + fraction clocks.
- R5: Writes to `div_int_i`/`div_frac_i` (strobed by `div_int_wr_i`/`div_frac_wr_i`) only update holding registers and leave `tick_o`, `invalid_o` and `abort_o` unchanged until a later `char_done_i`.
- R6: `char_done_i` high for one clock while a write is pending loads the held divisor and restarts the phase with the accumulator cleared. The first strobe then appears whole-part clocks after the loading edge, on the clock following the whole-part-th clock.
- R7: A running whole part of 0 drives `invalid_o` high and suppresses every strobe whatever the fraction. Strobes restart once a valid divisor is loaded.
- R8: A running whole part of 0xFFFF with a non-zero fraction drives `abort_o` high with `invalid_o` low and suppresses every strobe. 0xFFFF with fraction 0 clears `abort_o`.
- R9: `char_done_i` with no write pending since the last load leaves the strobe phase untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_int_wr_i | input | 1 | Write strobe for the held whole part |
| div_int_i | input | 16 | Whole part of the divisor |
| div_frac_wr_i | input | 1 | Write strobe for the held fraction |
| div_frac_i | input | 6 | Fraction of the divisor in 1/64 units |
| char_done_i | input | 1 | Character finished in transmitter or receiver |
| tick_o | output | 1 | Oversample strobe, one clock wide |
| invalid_o | output | 1 | Running whole part is zero |
| abort_o | output | 1 | Running divisor is 0xFFFF plus a non-zero fraction |

## Verification
A wrong down-counter value or a wrong accumulator value shows up at `tick_o` as a strobe that comes one or more clocks early or late. The counter error surfaces within one period. An accumulator error surfaces by the next wrap, which is at most 64 periods away. A divisor loaded at the wrong time shows up as a moved strobe or a changed flag on the first clock after the `char_done_i` edge that loaded it, or after the edge that should have. The bench steps a behavioural model alongside the design and compares all three outputs every clock, so any of these faults is caught on the first clock where a port differs.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 6;
endpackage

// File: rtl/fbg_div_stage.sv
module fbg_div_stage #(
  parameter int unsigned INT_W  = fbg_pkg::INT_W,
  parameter int unsigned FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_wr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic              frac_wr_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              char_done_i,
  output logic [INT_W-1:0]  stg_int_o,
  output logic [INT_W-1:0]  act_int_o,
  output logic [FRAC_W-1:0] act_frac_o,
  output logic              apply_o
);
  logic [INT_W-1:0]  stg_int_q, act_int_q;
  logic [FRAC_W-1:0] stg_frac_q, act_frac_q;
  logic              pend_q;

  assign apply_o = char_done_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_int_q  <= '0;
      stg_frac_q <= '0;
      act_int_q  <= '0;
      act_frac_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (int_wr_i)  stg_int_q  <= int_i;
      if (frac_wr_i) stg_frac_q <= frac_i;
      if (apply_o) begin
        act_int_q  <= stg_int_q;
        act_frac_q <= stg_frac_q;
      end
      // a write in the loading cycle stays pending for the next boundary
      if (int_wr_i || frac_wr_i) pend_q <= 1'b1;
      else if (apply_o)          pend_q <= 1'b0;
    end
  end

  assign stg_int_o  = stg_int_q;
  assign act_int_o  = act_int_q;
  assign act_frac_o = act_frac_q;
endmodule

// File: rtl/fbg_div_check.sv
module fbg_div_check #(
  parameter int unsigned INT_W  = fbg_pkg::INT_W,
  parameter int unsigned FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic [INT_W-1:0]  act_int_i,
  input  logic [FRAC_W-1:0] act_frac_i,
  output logic              invalid_o,
  output logic              abort_o,
  output logic              run_o
);
  localparam logic [INT_W-1:0] INT_MAX = '1;

  always_comb begin
    invalid_o = (act_int_i == '0);
    abort_o   = (act_int_i == INT_MAX) && (act_frac_i != '0);
    run_o     = !invalid_o && !abort_o;
  end
endmodule

// File: rtl/fbg_phase.sv
module fbg_phase #(
  parameter int unsigned INT_W  = fbg_pkg::INT_W,
  parameter int unsigned FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic              run_i,
  input  logic [INT_W-1:0]  stg_int_i,
  input  logic [INT_W-1:0]  act_int_i,
  input  logic [FRAC_W-1:0] act_frac_i,
  output logic [INT_W-1:0]  cnt_o,
  output logic              tick_o
);
  localparam logic [INT_W-1:0] ONE = INT_W'(1);

  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic [INT_W-1:0]  reload;
  logic              tick_q;

  always_comb begin
    acc_sum = {1'b0, acc_q} + {1'b0, act_frac_i};
    // wrap of the accumulator stretches the next period by one clock
    reload  = act_int_i - ONE + INT_W'(acc_sum[FRAC_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (apply_i) begin
      cnt_q  <= stg_int_i - ONE;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= run_i && (cnt_q == '0);
      if (run_i) begin
        if (cnt_q == '0) begin
          cnt_q <= reload;
          acc_q <= acc_sum[FRAC_W-1:0];
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned INT_W  = fbg_pkg::INT_W,
  parameter int unsigned FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_int_wr_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic              div_frac_wr_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              char_done_i,
  output logic              tick_o,
  output logic              invalid_o,
  output logic              abort_o
);
  logic [INT_W-1:0]  stg_int, act_int, cnt;
  logic [FRAC_W-1:0] act_frac;
  logic              apply, run;

  fbg_div_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_wr_i    (div_int_wr_i),
    .int_i       (div_int_i),
    .frac_wr_i   (div_frac_wr_i),
    .frac_i      (div_frac_i),
    .char_done_i (char_done_i),
    .stg_int_o   (stg_int),
    .act_int_o   (act_int),
    .act_frac_o  (act_frac),
    .apply_o     (apply)
  );

  fbg_div_check #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_check (
    .act_int_i  (act_int),
    .act_frac_i (act_frac),
    .invalid_o  (invalid_o),
    .abort_o    (abort_o),
    .run_o      (run)
  );

  fbg_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .apply_i    (apply),
    .run_i      (run),
    .stg_int_i  (stg_int),
    .act_int_i  (act_int),
    .act_frac_i (act_frac),
    .cnt_o      (cnt),
    .tick_o     (tick_o)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned INT_W = fbg_pkg::INT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_done_i,
  input logic             tick_o,
  input logic             invalid_o,
  input logic             abort_o,
  input logic [INT_W-1:0] act_int,
  input logic [INT_W-1:0] cnt
);
  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || act_int == INT_W'(1)));                 // R2
  AST_NO_TICK_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !tick_o);                                         // R7
  AST_NO_TICK_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !tick_o);                                           // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && abort_o));                                       // R8
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(char_done_i) |-> $stable(act_int));                      // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!invalid_o && !abort_o) |-> (cnt <= act_int));                 // R4
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .char_done_i (char_done_i),
  .tick_o      (tick_o),
  .invalid_o   (invalid_o),
  .abort_o     (abort_o),
  .act_int     (act_int),
  .cnt         (cnt)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_int = 1'b0, wr_frac = 1'b0, char_done = 1'b0;
  logic [15:0] int_in = '0;
  logic [5:0]  frac_in = '0;
  logic        tick, invalid, abort_f;

  int errors = 0, checks = 0, cycles = 0;

  frac_baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .div_int_wr_i(wr_int), .div_int_i(int_in),
    .div_frac_wr_i(wr_frac), .div_frac_i(frac_in),
    .char_done_i(char_done),
    .tick_o(tick), .invalid_o(invalid), .abort_o(abort_f)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_si, m_sf, m_ai, m_af, m_cnt, m_acc, m_s;
  bit m_pend, m_tick, m_run, m_app, m_tick_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_si = 0; m_sf = 0; m_ai = 0; m_af = 0; m_cnt = 0; m_acc = 0;
      m_pend = 0; m_tick = 0;
    end else begin
      m_run    = (m_ai != 0) && !(m_ai == 65535 && m_af != 0);
      m_app    = char_done && m_pend;
      m_tick_n = m_run && (m_cnt == 0) && !m_app;
      if (m_app) begin
        m_ai = m_si; m_af = m_sf; m_cnt = (m_si + 65535) % 65536; m_acc = 0;
      end else if (m_run) begin
        if (m_cnt == 0) begin
          m_s   = m_acc + m_af;
          m_cnt = m_ai - 1 + ((m_s >= 64) ? 1 : 0);
          m_acc = m_s % 64;
        end else m_cnt = m_cnt - 1;
      end
      if (wr_int || wr_frac) m_pend = 1;
      else if (m_app)        m_pend = 0;
      if (wr_int)  m_si = int_in;
      if (wr_frac) m_sf = frac_in;
      m_tick = m_tick_n;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(tick === m_tick, "R2 tick vs model", int'(tick), int'(m_tick));
      chk(invalid === (m_ai == 0), "R7 invalid vs model", int'(invalid), int'(m_ai == 0));
      chk(abort_f === (m_ai == 65535 && m_af != 0), "R8 abort vs model",
          int'(abort_f), int'(m_ai == 65535 && m_af != 0));
    end
  end

  initial begin
    @(negedge clk);
    while (cycles < 150000) @(negedge clk);
    chk(1'b0, "watchdog", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic write_div(input int iv, input int fv);
    @(negedge clk);
    wr_int = 1'b1; wr_frac = 1'b1; int_in = 16'(iv); frac_in = 6'(fv);
    @(negedge clk);
    wr_int = 1'b0; wr_frac = 1'b0;
  endtask

  task automatic boundary();
    @(negedge clk);
    char_done = 1'b1;
    @(negedge clk);
    char_done = 1'b0;
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 70000);
  endtask

  int n, sum, seen;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(invalid === 1'b1, "R1 invalid", int'(invalid), 1);
    chk(abort_f === 1'b0, "R1 abort", int'(abort_f), 0);
    chk(tick === 1'b0, "R1 tick", int'(tick), 0);
    rst_n = 1'b1;

    // R5 held write has no effect before a boundary
    write_div(3, 0);
    seen = 0;
    repeat (12) begin @(negedge clk); if (tick) seen++; end
    chk(invalid === 1'b1 && seen == 0, "R5 staged only", seen, 0);

    // R6 load and first strobe latency
    boundary();
    gap(n);
    chk(n == 3, "R6 first tick latency", n, 3);
    gap(n);
    chk(n == 3, "R3 period int=3", n, 3);

    // R3 whole part 1: strobe every clock
    write_div(1, 0);
    boundary();
    gap(n);
    seen = 0;
    repeat (20) begin @(negedge clk); if (tick) seen++; end
    chk(seen == 20, "R3 int=1 every clock", seen, 20);

    // R4 fractional average 3 + 5/64
    write_div(3, 5);
    boundary();
    gap(n);
    chk(n == 3, "R6 latency int=3", n, 3);
    sum = 0;
    for (int i = 0; i < 64; i++) begin gap(n); sum += n; end
    chk(sum == 197, "R4 64 periods 3+5/64", sum, 197);

    // R4 fractional half: periods alternate
    write_div(2, 32);
    boundary();
    gap(n);
    sum = 0;
    for (int i = 0; i < 64; i++) begin gap(n); sum += n; end
    chk(sum == 160, "R4 64 periods 2+32/64", sum, 160);

    // R9 boundary with nothing pending
    write_div(4, 0);
    boundary();
    gap(n);
    @(negedge clk);
    char_done = 1'b1;
    @(negedge clk);
    char_done = 1'b0;
    gap(n);
    chk(n == 2, "R9 phase kept", n, 2);
    gap(n);
    chk(n == 4, "R9 period kept", n, 4);

    // R7 zero whole part, fraction ignored
    write_div(0, 7);
    boundary();
    seen = 0;
    repeat (50) begin @(negedge clk); if (tick) seen++; end
    chk(invalid === 1'b1 && seen == 0, "R7 no ticks when invalid", seen, 0);

    // R8 abort condition
    write_div(65535, 1);
    boundary();
    seen = 0;
    repeat (50) begin @(negedge clk); if (tick) seen++; end
    chk(abort_f === 1'b1 && invalid === 1'b0 && seen == 0, "R8 abort no ticks", seen, 0);
    write_div(65535, 0);
    boundary();
    chk(abort_f === 1'b0, "R8 abort cleared", int'(abort_f), 0);

    // R7 clean restart from invalid
    write_div(0, 0);
    boundary();
    write_div(5, 0);
    boundary();
    gap(n);
    chk(n == 5, "R7 restart latency", n, 5);
    gap(n);
    chk(n == 5, "R3 period int=5", n, 5);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule